// File: doc/BRIEF.md
# Load/Store Effective Address and Base Update Unit

This block sits in the address-generation stage of a fixed-point load/store pipeline. Each cycle it may accept one memory instruction, already decoded into a base register number and value, an index register value, a target or source register number, a 16-bit immediate field, an addressing form, and update and store flags. One clock later it presents the 64-bit effective address. It also presents a decision on whether the base register must be overwritten with that address, the register number to write, and a flag that marks an update encoding the architecture forbids.

Four addressing forms are supported. The plain displacement form adds the sign-extended immediate. Two scaled forms take only the upper bits of the immediate as a word-aligned or quadword-aligned offset. The indexed form adds a second register instead of an immediate. A base register number of zero means a literal zero base, except in update forms. The legality rules for update forms differ between loads and stores. Memory access is done elsewhere.

Top module: `ea_unit`

## Requirements
- R1: With form_sel = 2'b00 (plain displacement), ea = base + sign_extend(imm[15:0]), computed modulo 2^64.
- R2: With form_sel = 2'b01 (word-scaled), the offset is sign_extend({imm[15:2], 2'b00}); imm[1:0] has no effect on ea.
- R3: With form_sel = 2'b10 (quadword-scaled), the offset is sign_extend({imm[15:4], 4'b0000}); imm[3:0] has no effect on ea.
- R4: With form_sel = 2'b11 (indexed), ea = base + rb_val and imm has no effect.
- R5: In a non-update instruction with ra_num = 0 the base is zero and ra_val has no effect; with ra_num != 0 the base is ra_val.
- R6: In an update instruction the base is always ra_val, for every ra_num.
- R7: A load update (is_update = 1, is_store = 0) with ra_num != 0 and ra_num != rt_num gives wb_en = 1 and wb_num = ra_num. Whenever wb_en = 0, wb_num reads 0.
- R8: A load update with ra_num = 0 or ra_num = rt_num gives bad_update = 1 and wb_en = 0.
- R9: A store update with ra_num != 0 gives wb_en = 1 and wb_num = ra_num, also when rt_num (the source register) equals ra_num.
- R10: A store update with ra_num = 0 gives bad_update = 1 and wb_en = 0.
- R11: A non-update instruction gives wb_en = 0 and bad_update = 0.
- R12: Outputs are registered with one cycle of latency: out_valid equals in_valid one cycle earlier, and wb_en and bad_update are 0 whenever out_valid is 0.
- R13: While rst is high at a clock edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is present this cycle |
| ra_num | input | 5 | Base register number |
| ra_val | input | 64 | Base register contents |
| rb_val | input | 64 | Index register contents |
| rt_num | input | 5 | Load target or store source register number |
| imm | input | 16 | Raw immediate field |
| form_sel | input | 2 | Addressing form: 00 displacement, 01 word-scaled, 10 quadword-scaled, 11 indexed |
| is_update | input | 1 | Update form: write the address back to the base register |
| is_store | input | 1 | 1 for store, 0 for load |
| out_valid | output | 1 | Registered copy of in_valid |
| ea | output | 64 | Effective address |
| wb_en | output | 1 | Write ea into register wb_num |
| wb_num | output | 5 | Register number to write back |
| bad_update | output | 1 | The update encoding is not allowed |

## Verification
The clocked properties assume that the decode inputs are stable and meaningful in every cycle where in_valid is high. They relate those inputs to the outputs one edge later, and they do not hold across the edge where reset is released. The stimulus changes every input only on the falling edge. It sweeps all four forms, both update settings and both directions over base and target numbers that include zero, equal pairs and the top register. Random register contents feed the sweep, and directed operands push the adder through wrap-around and negative offsets.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    FORM_D  = 2'd0,
    FORM_DS = 2'd1,
    FORM_DQ = 2'd2,
    FORM_X  = 2'd3
  } addr_form_e;
endpackage

// File: rtl/ea_offset_sel.sv
module ea_offset_sel
  import ea_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int IMM_W    = 16,
  parameter int DS_SHIFT = 2,
  parameter int DQ_SHIFT = 4
) (
  input  addr_form_e        form,
  input  logic [IMM_W-1:0]  imm,
  input  logic [XLEN-1:0]   rb_val,
  output logic [XLEN-1:0]   offset
);
  localparam int EXT_W = XLEN - IMM_W;
  localparam logic [XLEN-1:0] ONES    = '1;
  localparam logic [XLEN-1:0] DS_MASK = ONES << DS_SHIFT;
  localparam logic [XLEN-1:0] DQ_MASK = ONES << DQ_SHIFT;

  logic [XLEN-1:0] sext_imm;

  // Sign extension first, then clearing the low bits, gives the same value
  // as appending zeros to the scaled field and extending that.
  assign sext_imm = {{EXT_W{imm[IMM_W-1]}}, imm};

  always_comb begin
    case (form)
      FORM_D:  offset = sext_imm;
      FORM_DS: offset = sext_imm & DS_MASK;
      FORM_DQ: offset = sext_imm & DQ_MASK;
      FORM_X:  offset = rb_val;
      default: offset = sext_imm;
    endcase
  end
endmodule

// File: rtl/ea_base_sel.sv
module ea_base_sel #(
  parameter int XLEN = 64,
  parameter int RN_W = 5
) (
  input  logic [RN_W-1:0] ra_num,
  input  logic [XLEN-1:0] ra_val,
  input  logic            is_update,
  output logic [XLEN-1:0] base
);
  logic zero_base;

  assign zero_base = !is_update && (ra_num == '0);
  assign base      = zero_base ? '0 : ra_val;
endmodule

// File: rtl/ea_update_ctl.sv
module ea_update_ctl #(
  parameter int RN_W = 5
) (
  input  logic            valid,
  input  logic            is_update,
  input  logic            is_store,
  input  logic [RN_W-1:0] ra_num,
  input  logic [RN_W-1:0] rt_num,
  output logic            wb_en,
  output logic [RN_W-1:0] wb_num,
  output logic            bad
);
  logic ra_zero;
  logic ra_hits_rt;
  logic illegal;

  assign ra_zero    = (ra_num == '0);
  assign ra_hits_rt = (ra_num == rt_num);

  // Loads lose the loaded value if the base is also the target; stores read
  // the source before the write-back, so only a zero base is illegal there.
  assign illegal = ra_zero || (!is_store && ra_hits_rt);

  assign bad    = valid && is_update && illegal;
  assign wb_en  = valid && is_update && !illegal;
  assign wb_num = wb_en ? ra_num : '0;
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int RN_W     = 5,
  parameter int IMM_W    = 16,
  parameter int DS_SHIFT = 2,
  parameter int DQ_SHIFT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [RN_W-1:0] ra_num,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  input  logic [RN_W-1:0] rt_num,
  input  logic [IMM_W-1:0] imm,
  input  logic [1:0]      form_sel,
  input  logic            is_update,
  input  logic            is_store,
  output logic            out_valid,
  output logic [XLEN-1:0] ea,
  output logic            wb_en,
  output logic [RN_W-1:0] wb_num,
  output logic            bad_update
);
  addr_form_e      form;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] ea_next;
  logic            wb_next;
  logic [RN_W-1:0] wb_num_next;
  logic            bad_next;

  assign form = addr_form_e'(form_sel);

  ea_base_sel #(.XLEN(XLEN), .RN_W(RN_W)) u_base (
    .ra_num    (ra_num),
    .ra_val    (ra_val),
    .is_update (is_update),
    .base      (base)
  );

  ea_offset_sel #(
    .XLEN(XLEN), .IMM_W(IMM_W), .DS_SHIFT(DS_SHIFT), .DQ_SHIFT(DQ_SHIFT)
  ) u_off (
    .form   (form),
    .imm    (imm),
    .rb_val (rb_val),
    .offset (offset)
  );

  ea_update_ctl #(.RN_W(RN_W)) u_upd (
    .valid     (in_valid),
    .is_update (is_update),
    .is_store  (is_store),
    .ra_num    (ra_num),
    .rt_num    (rt_num),
    .wb_en     (wb_next),
    .wb_num    (wb_num_next),
    .bad       (bad_next)
  );

  // Carry out of the top bit is dropped: the address wraps.
  assign ea_next = base + offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      ea         <= '0;
      wb_en      <= 1'b0;
      wb_num     <= '0;
      bad_update <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      ea         <= ea_next;
      wb_en      <= wb_next;
      wb_num     <= wb_num_next;
      bad_update <= bad_next;
    end
  end

  p_lat_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!wb_en && !bad_update));

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(wb_en && bad_update));

  p_load_clash_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_update && !is_store && (ra_num == rt_num))
      |=> (bad_update && !wb_en));

  p_store_wb_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_update && is_store && (ra_num != '0))
      |=> (wb_en && (wb_num == $past(ra_num))));

  p_no_upd_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_update) |=> (!wb_en && !bad_update));

  p_wb_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_num != '0));
endmodule

// File: tb/sim_ea_unit.sv
`timescale 1ns/1ps
module sim_ea_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [4:0]  ra_num, rt_num;
  logic [63:0] ra_val, rb_val;
  logic [15:0] imm;
  logic [1:0]  form_sel;
  logic        is_update, is_store;
  logic        out_valid;
  logic [63:0] ea;
  logic        wb_en;
  logic [4:0]  wb_num;
  logic        bad_update;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ea_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ra_num(ra_num),
    .ra_val(ra_val), .rb_val(rb_val), .rt_num(rt_num), .imm(imm),
    .form_sel(form_sel), .is_update(is_update), .is_store(is_store),
    .out_valid(out_valid), .ea(ea), .wb_en(wb_en), .wb_num(wb_num),
    .bad_update(bad_update)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_ea(logic [1:0] f, logic upd, logic [4:0] ra,
      logic [63:0] rav, logic [63:0] rbv, logic [15:0] im);
    logic [63:0] b, d;
    b = (!upd && ra == 5'd0) ? 64'd0 : rav;
    d = 64'($signed(im));
    case (f)
      2'd0: d = d;
      2'd1: d = 64'($signed({im[15:2], 2'b00}));
      2'd2: d = 64'($signed({im[15:4], 4'b0000}));
      default: d = rbv;
    endcase
    return b + d;
  endfunction

  function automatic string ea_tag(logic [1:0] f);
    case (f)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  // Applies one instruction right after a falling edge; checks at the next one.
  task automatic run_vec(input logic [1:0] f, input logic upd, input logic st,
      input logic [4:0] ra, input logic [4:0] rt, input logic [63:0] rav,
      input logic [63:0] rbv, input logic [15:0] im, input string etag);
    logic exp_bad, exp_wb;
    string wtag;
    in_valid = 1'b1; form_sel = f; is_update = upd; is_store = st;
    ra_num = ra; rt_num = rt; ra_val = rav; rb_val = rbv; imm = im;
    exp_bad = upd && (ra == 5'd0 || (!st && ra == rt));
    exp_wb  = upd && !exp_bad;
    if (!upd) wtag = "R11";
    else if (st) wtag = (ra == 5'd0) ? "R10" : "R9";
    else wtag = exp_bad ? "R8" : "R7";
    @(negedge clk);
    chk("R12 out_valid", 64'(out_valid), 64'd1);
    chk(etag, ea, model_ea(f, upd, ra, rav, rbv, im));
    chk({wtag, " wb_en"}, 64'(wb_en), 64'(exp_wb));
    chk({wtag, " wb_num"}, 64'(wb_num), exp_wb ? 64'(ra) : 64'd0);
    chk({wtag, " bad_update"}, 64'(bad_update), 64'(exp_bad));
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b1; ra_num = 5'd3; rt_num = 5'd4;
    ra_val = 64'h1234; rb_val = 64'h10; imm = 16'h0040; form_sel = 2'd0;
    is_update = 1'b1; is_store = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13 out_valid", 64'(out_valid), 64'd0);
    chk("R13 ea", ea, 64'd0);
    chk("R13 wb_en", 64'(wb_en), 64'd0);
    chk("R13 wb_num", 64'(wb_num), 64'd0);
    chk("R13 bad_update", 64'(bad_update), 64'd0);
    rst = 1'b0;

    // Sweep of form, update, direction, base and target numbers.
    for (int f = 0; f < 4; f++)
      for (int u = 0; u < 2; u++)
        for (int s = 0; s < 2; s++)
          for (int a = 0; a < 4; a++)
            for (int t = 0; t < 4; t++) begin
              logic [4:0] pick [4];
              pick[0] = 5'd0; pick[1] = 5'd1; pick[2] = 5'd5; pick[3] = 5'd31;
              run_vec(2'(f), 1'(u), 1'(s), pick[a], pick[t],
                      {$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom),
                      ea_tag(2'(f)));
            end

    // Directed corner cases.
    run_vec(2'd0, 1'b0, 1'b0, 5'd2, 5'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h0001, "R1 wrap");
    run_vec(2'd0, 1'b0, 1'b0, 5'd2, 5'd3, 64'h0000_0000_0000_0100, 64'd0, 16'h8000, "R1 negative");
    run_vec(2'd1, 1'b0, 1'b0, 5'd2, 5'd3, 64'h1000, 64'd0, 16'h0007, "R2 low bits ignored");
    run_vec(2'd1, 1'b0, 1'b0, 5'd2, 5'd3, 64'h1000, 64'd0, 16'hFFFF, "R2 negative");
    run_vec(2'd2, 1'b0, 1'b0, 5'd2, 5'd3, 64'h1000, 64'd0, 16'h001F, "R3 low bits ignored");
    run_vec(2'd2, 1'b0, 1'b0, 5'd2, 5'd3, 64'h1000, 64'd0, 16'hFFF0, "R3 negative");
    run_vec(2'd3, 1'b0, 1'b0, 5'd2, 5'd3, 64'h1000, 64'h0234, 16'h7FFF, "R4 imm ignored");
    run_vec(2'd0, 1'b0, 1'b0, 5'd0, 5'd3, 64'hDEAD_BEEF_0000_0000, 64'd0, 16'h0010, "R5 zero base");
    run_vec(2'd3, 1'b0, 1'b1, 5'd0, 5'd3, 64'h5555_0000_0000_0000, 64'h40, 16'd0, "R5 zero base indexed");
    run_vec(2'd0, 1'b1, 1'b0, 5'd0, 5'd3, 64'h0000_0000_0000_8000, 64'd0, 16'h0008, "R6 update base");
    run_vec(2'd3, 1'b1, 1'b1, 5'd9, 5'd9, 64'h0000_0000_0001_0000, 64'h20, 16'd0, "R6 R9 store same reg");

    // Idle cycle after update traffic: nothing may be flagged.
    in_valid = 1'b0; is_update = 1'b1; is_store = 1'b1; ra_num = 5'd7;
    @(negedge clk);
    chk("R12 idle out_valid", 64'(out_valid), 64'd0);
    chk("R12 idle wb_en", 64'(wb_en), 64'd0);
    chk("R12 idle bad_update", 64'(bad_update), 64'd0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule